// File: doc/BRIEF.md
# Checkpoint Fault-Injection Comparator Harness

This block wraps a six-gate NAND benchmark netlist with five primary inputs and two outputs. It lets a test controller force single or multiple stuck-at faults onto the checkpoint lines of that netlist. The checkpoint lines are the primary inputs plus every fanout branch. Each one passes through a 2:1 injection multiplexer. A select bit either lets the true signal through or replaces it with the level on a shared stuck-value input.

An untouched copy of the same netlist runs alongside the injected copy. Both sets of outputs are visible, and their bitwise XOR is ORed into a single mismatch flag that is registered on the clock. A controller sets the inputs, picks the checkpoints to corrupt and reads the mismatch flag one clock later to learn whether the applied vector exposes the fault.

Netlist, with inputs pi[0..4] named x1, x2, x3, x6, x7: na = NAND(x1, x3), nb = NAND(x3, x6), nc = NAND(x2, nb), nd = NAND(nb, x7), out[0] = NAND(na, nc), out[1] = NAND(nc, nd).

Top module: `cpfi_top`

## Requirements
- R1: When `rst_n` is low at a rising edge, `mismatch` reads 0 after that edge.
- R2: With `cp_sel` all zero, `faulty_out` equals `golden_out` for every input vector, and `mismatch` is 0 one cycle later.
- R3: `golden_out` always equals the fault-free netlist function of `pi`, whatever `cp_sel` and `stuck_val` are.
- R4: The fault-free function is out[0] = NAND(NAND(x1,x3), NAND(x2,NAND(x3,x6))) and out[1] = NAND(NAND(x2,NAND(x3,x6)), NAND(NAND(x3,x6),x7)), where x1=pi[0], x2=pi[1], x3=pi[2], x6=pi[3], x7=pi[4].
- R5: Setting `cp_sel[k]` replaces checkpoint k with `stuck_val` in the injected copy. Index map: 0..4 are the stems of pi[0..4]; 5 is the x3 branch into na; 6 is the x3 branch into nb; 7 is the nb branch into nc; 8 is the nb branch into nd; 9 is the nc branch into out[0]; 10 is the nc branch into out[1].
- R6: A fault on the x3 stem (index 2) reaches both of its branches, but a fault on one branch (index 5 or 6) leaves the other branch at the true value. With all inputs at 1, golden is 2'b01; a stem stuck-at-0 gives 2'b11; a stuck-at-0 on branch 5 gives 2'b00; a stuck-at-0 on branch 6 gives 2'b11.
- R7: After a clock edge taken out of reset, `mismatch` is 1 exactly when `faulty_out` differed from `golden_out` in any bit just before that edge.
- R8: When several `cp_sel` bits are set together, all the selected checkpoints are forced to `stuck_val` at the same time.
- R9: Reset is synchronous and takes priority: a differing output pair present while `rst_n` is low still leaves `mismatch` at 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pi | input | 5 | Primary inputs x1,x2,x3,x6,x7 in bits 0..4 |
| cp_sel | input | 11 | Per-checkpoint injection select |
| stuck_val | input | 1 | Level forced on selected checkpoints |
| faulty_out | output | 2 | Outputs of the injected copy |
| golden_out | output | 2 | Outputs of the fault-free copy |
| mismatch | output | 1 | Registered OR of output differences |

## Verification
Reset and a real detection can fall on the same clock edge. The bench provokes this by holding `rst_n` low while a stem fault is active on a vector that exposes it, so the outputs visibly differ at the edge. The registered flag must still read 0 afterwards, and on the next edge with reset released it must rise for the same stimulus. Every single stuck-at fault is swept across all 32 input vectors against a behavioural model that forces the same lines.

// File: rtl/cpfi_pkg.sv
// Shared sizes and checkpoint numbering for the fault-injection harness.
// Assumes the fixed six-NAND netlist; indices here are decoded by the netlist.
package cpfi_pkg;
    localparam int PI_W = 5;
    localparam int PO_W = 2;
    localparam int NUM_STEM = PI_W;
    localparam int NUM_BRANCH = 6;
    localparam int CP_W = NUM_STEM + NUM_BRANCH;

    // Branch checkpoints (stems occupy 0..PI_W-1 in input order)
    localparam int CP_X3_TO_NA = 5;
    localparam int CP_X3_TO_NB = 6;
    localparam int CP_NB_TO_NC = 7;
    localparam int CP_NB_TO_ND = 8;
    localparam int CP_NC_TO_O0 = 9;
    localparam int CP_NC_TO_O1 = 10;
endpackage

// File: rtl/cpfi_inj_mux.sv
// One checkpoint injection point. With EN set, a 2:1 mux chooses the true
// line or the forced level. With EN clear, the line passes straight through,
// so a fault-free copy carries no mux logic. Assumes sel is active high.
module cpfi_inj_mux #(
    parameter bit EN = 1'b1
) (
    input  logic orig,
    input  logic sel,
    input  logic stuck,
    output logic y
);
    generate
        if (EN) begin : g_mux
            // Choose between the true signal and the forced level
            assign y = sel ? stuck : orig;
        end else begin : g_wire
            logic unused_ign;
            // Pass-through; the select and stuck level are deliberately ignored
            assign unused_ign = sel ^ stuck;
            assign y = orig;
        end
    endgenerate
endmodule

// File: rtl/cpfi_netlist.sv
// Six-NAND benchmark netlist with an injection point on every checkpoint
// (input stems and fanout branches). INJECT=0 builds a fault-free copy.
// Assumes branch muxes take the stem-mux output, so a stem fault reaches
// every branch of that stem.
module cpfi_netlist
    import cpfi_pkg::*;
#(
    parameter bit INJECT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PI_W-1:0] pi,
    input  logic [CP_W-1:0] cp_sel,
    input  logic            stuck_val,
    output logic [PO_W-1:0] po
);
    logic [CP_W-1:0] cp_in;
    logic [CP_W-1:0] cp_out;
    logic n_a, n_b, n_c, n_d;

    // Stem checkpoints are the primary inputs themselves
    assign cp_in[NUM_STEM-1:0] = pi;
    // Fanout branches of x3, nb and nc
    assign cp_in[CP_X3_TO_NA] = cp_out[2];
    assign cp_in[CP_X3_TO_NB] = cp_out[2];
    assign cp_in[CP_NB_TO_NC] = n_b;
    assign cp_in[CP_NB_TO_ND] = n_b;
    assign cp_in[CP_NC_TO_O0] = n_c;
    assign cp_in[CP_NC_TO_O1] = n_c;

    genvar k;
    generate
        for (k = 0; k < CP_W; k++) begin : g_cp
            cpfi_inj_mux #(.EN(INJECT)) u_mux (
                .orig (cp_in[k]),
                .sel  (cp_sel[k]),
                .stuck(stuck_val),
                .y    (cp_out[k])
            );
        end
    endgenerate

    // Gate level of the benchmark, reading only checkpoint outputs
    assign n_a   = ~(cp_out[0] & cp_out[CP_X3_TO_NA]);
    assign n_b   = ~(cp_out[CP_X3_TO_NB] & cp_out[3]);
    assign n_c   = ~(cp_out[1] & cp_out[CP_NB_TO_NC]);
    assign n_d   = ~(cp_out[CP_NB_TO_ND] & cp_out[4]);
    assign po[0] = ~(n_a & cp_out[CP_NC_TO_O0]);
    assign po[1] = ~(cp_out[CP_NC_TO_O1] & n_d);

    generate
        if (INJECT) begin : g_chk
            // A stem fault on x3 must show up on the unselected branch into na
            assert_stem_to_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cp_sel[2] && !cp_sel[CP_X3_TO_NA]) |-> (cp_out[CP_X3_TO_NA] == stuck_val));
        end
    endgenerate
endmodule

// File: rtl/cpfi_compare.sv
// XOR compare of faulty and golden outputs, ORed and registered.
// Assumes synchronous active-low reset; detection appears one edge later.
module cpfi_compare
    import cpfi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PO_W-1:0] faulty,
    input  logic [PO_W-1:0] golden,
    output logic            detect
);
    logic [PO_W-1:0] diff;
    logic            any_diff;

    // Bitwise difference and reduction to a single hit
    assign diff     = faulty ^ golden;
    assign any_diff = |diff;

    // Register the hit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) detect <= 1'b0;
        else        detect <= any_diff;
    end

    // Equal outputs before an edge out of reset give no detection after it
    assert_quiet_when_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(faulty) == $past(golden))) |-> !detect);
endmodule

// File: rtl/cpfi_top.sv
// Fault-injection harness: an injected netlist copy, a fault-free copy and a
// registered mismatch flag. Assumes the controller holds inputs steady
// around the clock edge it samples on.
module cpfi_top
    import cpfi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PI_W-1:0] pi,
    input  logic [CP_W-1:0] cp_sel,
    input  logic            stuck_val,
    output logic [PO_W-1:0] faulty_out,
    output logic [PO_W-1:0] golden_out,
    output logic            mismatch
);
    cpfi_netlist #(.INJECT(1'b1)) u_faulty (
        .clk      (clk),
        .rst_n    (rst_n),
        .pi       (pi),
        .cp_sel   (cp_sel),
        .stuck_val(stuck_val),
        .po       (faulty_out)
    );

    cpfi_netlist #(.INJECT(1'b0)) u_golden (
        .clk      (clk),
        .rst_n    (rst_n),
        .pi       (pi),
        .cp_sel   (cp_sel),
        .stuck_val(stuck_val),
        .po       (golden_out)
    );

    cpfi_compare u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .faulty(faulty_out),
        .golden(golden_out),
        .detect(mismatch)
    );

    // Reset edge always leaves the flag low
    assert_reset_clears_R9: assert property (@(posedge clk)
        !$past(rst_n) |-> !mismatch);
    // No selects means the two copies agree
    assert_no_sel_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_sel == '0) |-> (faulty_out == golden_out));
    // Golden copy follows the inputs only
    assert_golden_ignores_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pi) |-> $stable(golden_out));
    // A detection requires some fault to have been selected
    assert_detect_needs_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && $past(rst_n)) |-> ($past(cp_sel) != '0));
endmodule

// File: tb/cpfi_top_tb_top.sv
module cpfi_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  pi = '0;
    logic [10:0] cp_sel = '0;
    logic        stuck_val = 1'b0;
    logic [1:0]  faulty_out, golden_out;
    logic        mismatch;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_det;
        string tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    sb_item_t mon_it;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpfi_top dut_i (
        .clk(clk), .rst_n(rst_n), .pi(pi), .cp_sel(cp_sel), .stuck_val(stuck_val),
        .faulty_out(faulty_out), .golden_out(golden_out), .mismatch(mismatch)
    );

    // Behavioural reference: evaluate the netlist with selected lines forced
    function automatic logic [1:0] ref_eval(logic [4:0] p, logic [10:0] s, logic v);
        logic x1, x2, x3, x6, x7, x3a, x3b, a, b, bc, bd, c, d, ce, cf;
        x1 = s[0] ? v : p[0];
        x2 = s[1] ? v : p[1];
        x3 = s[2] ? v : p[2];
        x6 = s[3] ? v : p[3];
        x7 = s[4] ? v : p[4];
        x3a = s[5] ? v : x3;
        x3b = s[6] ? v : x3;
        a = ~(x1 & x3a);
        b = ~(x3b & x6);
        bc = s[7] ? v : b;
        bd = s[8] ? v : b;
        c = ~(x2 & bc);
        d = ~(bd & x7);
        ce = s[9] ? v : c;
        cf = s[10] ? v : c;
        return {~(cf & d), ~(a & ce)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: apply stimulus off the edge, check the combinational outputs, queue the flag
    task automatic drive(input logic [4:0] p, input logic [10:0] s, input logic v,
                         input logic r, input string tag);
        logic [1:0] ef, eg;
        sb_item_t it;
        @(negedge clk);
        pi = p; cp_sel = s; stuck_val = v; rst_n = r;
        #1;
        eg = ref_eval(p, '0, v);
        ef = ref_eval(p, s, v);
        check(golden_out === eg, {tag, "/R3 R4 golden"}, golden_out, eg);
        check(faulty_out === ef, {tag, "/R5 faulty"}, faulty_out, ef);
        it.exp_det = r ? (ef != eg) : 1'b0;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each edge compare the registered flag against the queued expectation
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            mon_it = sb_q.pop_front();
            check(mismatch === mon_it.exp_det, {mon_it.tag, "/R7 mismatch"},
                  {1'b0, mismatch}, {1'b0, mon_it.exp_det});
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // R1: flag low under reset
        repeat (2) @(posedge clk);
        #1;
        check(mismatch === 1'b0, "R1 reset state", {1'b0, mismatch}, 2'b00);

        // R2: no selects, every vector, outputs agree
        for (int p = 0; p < 32; p++) begin
            drive(p[4:0], '0, p[0], 1'b1, "R2 no fault");
            check(faulty_out === golden_out, "R2 agree", faulty_out, golden_out);
        end

        // R5: every single stuck-at fault across all vectors
        for (int k = 0; k < 11; k++)
            for (int v = 0; v < 2; v++)
                for (int p = 0; p < 32; p++)
                    drive(p[4:0], 11'(1) << k, v[0], 1'b1, "R5 single fault");

        // R6: stem versus branch faults on x3, all inputs high
        drive(5'b11111, '0, 1'b0, 1'b1, "R6 golden");
        check(golden_out === 2'b01, "R6 golden value", golden_out, 2'b01);
        drive(5'b11111, 11'b000_0000_0100, 1'b0, 1'b1, "R6 stem");
        check(faulty_out === 2'b11, "R6 stem sa0", faulty_out, 2'b11);
        drive(5'b11111, 11'b000_0010_0000, 1'b0, 1'b1, "R6 branch na");
        check(faulty_out === 2'b00, "R6 branch5 sa0", faulty_out, 2'b00);
        drive(5'b11111, 11'b000_0100_0000, 1'b0, 1'b1, "R6 branch nb");
        check(faulty_out === 2'b11, "R6 branch6 sa0", faulty_out, 2'b11);

        // R8: multiple simultaneous faults
        for (int p = 0; p < 32; p++) begin
            drive(p[4:0], 11'b100_1000_0011, 1'b1, 1'b1, "R8 multi sa1");
            drive(p[4:0], 11'b011_0110_0100, 1'b0, 1'b1, "R8 multi sa0");
        end

        // R9: reset held while outputs differ, then released with the same stimulus
        drive(5'b11111, 11'b000_0000_0100, 1'b0, 1'b0, "R9 reset over detect");
        check(faulty_out !== golden_out, "R9 outputs differ", faulty_out, ~golden_out);
        drive(5'b11111, 11'b000_0000_0100, 1'b0, 1'b1, "R9 release");

        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule